// File: doc/BRIEF.md
# DLL Enable and Lock Supervisor

This block brings up the delay-locked loop of a high-speed card interface before sampling-point tuning begins. On a request it first refuses to act when the card clock is at or below the high-speed threshold. It then reads the current DLL control word and, if the loop is already on, leaves it alone. Otherwise it writes back a control word with the loop enabled, fast lock on, bypass off, both phase selects at a quarter-cycle and the update strobe raised, and waits a bounded time for the lock indication.

Once lock is seen, or when the loop was already enabled, the measured DLL delay is divided by a programmable 8-bit divider. The quotient is clamped to the width of the step field and presented to the tuning engine, together with the configured number of consecutive good sampling points needed. Every request ends with a one-cycle `done` pulse. The two error flags tell a rejected clock apart from a lock timeout.

Top module: `dll_lock_supervisor`

## Requirements
- R1: After synchronous reset, `done`, `dll_ctrl_we`, both error flags, `tune_step` and `tune_consec` are all 0.
- R2: A request with `card_khz` at or below SLOW_KHZ (default 52000) ends with `done` and `err_slow_clk`=1, and no write to the DLL control word happens.
- R3: If bit 31 of `dll_ctrl_rd` is set at the request, no control write happens and the request goes straight to the step calculation.
- R4: The enable write keeps every bit of `dll_ctrl_rd` except these: it sets bit 31 (enable) and bit 5 (fast lock), clears bit 0 (bypass), and loads 6'h1F into bits [21:16] and [29:24].
- R5: With `new_variant`=1 the enable write sets bit 23 and clears bit 30. With `new_variant`=0 it sets bit 30.
- R6: If the synchronised `dll_lock` is seen within LOCK_CYCLES clock cycles after the write, the request succeeds. If it is not seen, the request ends with `err_lock_timeout`=1 and `tune_step` is left unchanged.
- R7: On success, `tune_step` equals floor(`dll_delay` / `step_div`), and a divider of 0 is treated as 1.
- R8: A quotient above 2^STEP_W-1 is clamped to 2^STEP_W-1.
- R9: On success, `tune_consec` takes the value of `consec_cfg`. The two error flags are never both set.
- R10: `dll_ctrl_we` is a single-cycle pulse, and it is issued at most once per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when idle |
| card_khz | input | FREQ_W | Card clock frequency in kHz |
| new_variant | input | 1 | Selects the newer control-word layout |
| dll_ctrl_rd | input | 32 | Current DLL control word |
| dll_lock | input | 1 | Lock indication from the DLL (asynchronous) |
| dll_delay | input | DLY_W | Current measured DLL delay |
| step_div | input | 8 | Tuning step divider |
| consec_cfg | input | CONS_W | Required consecutive good sampling points |
| dll_ctrl_wr | output | 32 | Control word to write |
| dll_ctrl_we | output | 1 | Write strobe for `dll_ctrl_wr` |
| done | output | 1 | One-cycle end-of-request pulse |
| err_slow_clk | output | 1 | Request rejected: clock too slow |
| err_lock_timeout | output | 1 | Lock not seen within the window |
| tune_step | output | STEP_W | Saturated tuning step |
| tune_consec | output | CONS_W | Consecutive-success count for tuning |

## Verification
The hardest case to reach from the ports is the lock timeout: the window must expire while the delay path and the divider are never engaged. The bench shortens LOCK_CYCLES and holds `dll_lock` low for a whole request. It also raises lock late in the window, so that a late lock is shown to differ from no lock at all. The divider's saturation edge and its zero-divider case are reached by choosing delay and divider values whose quotients sit exactly at, just above and far above the clamp.

// File: rtl/dll_sup_pkg.sv
package dll_sup_pkg;
  // positions decoded by the DLL itself
  localparam int unsigned EN_BIT    = 31;
  localparam int unsigned REFSEL_BIT = 30;
  localparam int unsigned UPD_NEW_BIT = 23;
  localparam int unsigned UPD_OLD_BIT = 30;
  localparam int unsigned FLOCK_BIT = 5;
  localparam int unsigned BYP_BIT   = 0;
  localparam int unsigned PH0_LSB   = 16;
  localparam int unsigned PH1_LSB   = 24;
  localparam int unsigned PH_W      = 6;
  localparam logic [PH_W-1:0] PH_QUARTER = 6'h1F;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_CALC = 2'd2
  } sup_state_e;
endpackage

// File: rtl/dll_word_build.sv
module dll_word_build
  import dll_sup_pkg::*;
(
  input  logic [31:0] cur_word,
  input  logic        new_variant,
  output logic [31:0] en_word
);
  always_comb begin
    en_word = cur_word;
    en_word[EN_BIT]    = 1'b1;
    en_word[FLOCK_BIT] = 1'b1;
    en_word[BYP_BIT]   = 1'b0;
    en_word[PH0_LSB +: PH_W] = PH_QUARTER;
    en_word[PH1_LSB +: PH_W] = PH_QUARTER;
    if (new_variant) begin
      en_word[UPD_NEW_BIT] = 1'b1;
      en_word[REFSEL_BIT]  = 1'b0;
    end else begin
      en_word[UPD_OLD_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/dll_lock_timer.sv
module dll_lock_timer #(
  parameter int unsigned LIMIT = 6400000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/dll_step_div.sv
module dll_step_div #(
  parameter int unsigned DLY_W = 10,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DLY_W-1:0] dividend,
  input  logic [DIV_W-1:0] divisor,
  output logic             fin,
  output logic [DLY_W-1:0] quot
);
  localparam int unsigned IW = $clog2(DLY_W + 1);
  localparam int unsigned PW = DLY_W + DIV_W + 1;

  logic [DIV_W-1:0] rem;
  logic [DIV_W-1:0] d_q;
  logic [DLY_W-1:0] n_q;
  logic [IW-1:0]    left;
  logic             busy;
  logic [DIV_W:0]   trial;

  assign trial = {rem, quot[DLY_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      d_q  <= '0;
      n_q  <= '0;
      quot <= '0;
      left <= '0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem  <= '0;
        quot <= dividend;
        n_q  <= dividend;
        d_q  <= (divisor == '0) ? DIV_W'(1) : divisor;
        left <= IW'(DLY_W);
        busy <= 1'b1;
      end else if (busy) begin
        if (trial >= {1'b0, d_q}) begin
          rem  <= DIV_W'(trial - {1'b0, d_q});
          quot <= {quot[DLY_W-2:0], 1'b1};
        end else begin
          rem  <= trial[DIV_W-1:0];
          quot <= {quot[DLY_W-2:0], 1'b0};
        end
        left <= left - 1'b1;
        if (left == IW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  // R7
  quot_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> ((PW'(quot) * PW'(d_q) <= PW'(n_q)) &&
             (PW'(n_q) < (PW'(quot) + PW'(1)) * PW'(d_q))));
endmodule

// File: rtl/dll_lock_supervisor.sv
module dll_lock_supervisor
  import dll_sup_pkg::*;
#(
  parameter int unsigned FREQ_W      = 20,
  parameter int unsigned SLOW_KHZ    = 52000,
  parameter int unsigned LOCK_CYCLES = 6400000,
  parameter int unsigned DLY_W       = 10,
  parameter int unsigned STEP_W      = 6,
  parameter int unsigned CONS_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FREQ_W-1:0] card_khz,
  input  logic              new_variant,
  input  logic [31:0]       dll_ctrl_rd,
  input  logic              dll_lock,
  input  logic [DLY_W-1:0]  dll_delay,
  input  logic [7:0]        step_div,
  input  logic [CONS_W-1:0] consec_cfg,
  output logic [31:0]       dll_ctrl_wr,
  output logic              dll_ctrl_we,
  output logic              done,
  output logic              err_slow_clk,
  output logic              err_lock_timeout,
  output logic [STEP_W-1:0] tune_step,
  output logic [CONS_W-1:0] tune_consec
);
  localparam logic [FREQ_W-1:0] SLOW_LIM = FREQ_W'(SLOW_KHZ);
  localparam logic [DLY_W-1:0]  STEP_MAX = DLY_W'((1 << STEP_W) - 1);

  sup_state_e       state;
  logic [31:0]      en_word;
  logic [1:0]       lock_sync;
  logic             win_over;
  logic             div_go;
  logic             div_fin;
  logic [DLY_W-1:0] div_q;
  logic             too_slow;

  assign too_slow = (card_khz <= SLOW_LIM);

  dll_word_build u_word (
    .cur_word   (dll_ctrl_rd),
    .new_variant(new_variant),
    .en_word    (en_word)
  );

  dll_lock_timer #(.LIMIT(LOCK_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (state == S_WAIT),
    .expired(win_over)
  );

  dll_step_div #(.DLY_W(DLY_W), .DIV_W(8)) u_div (
    .clk     (clk),
    .rst     (rst),
    .go      (div_go),
    .dividend(dll_delay),
    .divisor (step_div),
    .fin     (div_fin),
    .quot    (div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) lock_sync <= '0;
    else     lock_sync <= {lock_sync[0], dll_lock};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state            <= S_IDLE;
      dll_ctrl_wr      <= '0;
      dll_ctrl_we      <= 1'b0;
      done             <= 1'b0;
      err_slow_clk     <= 1'b0;
      err_lock_timeout <= 1'b0;
      tune_step        <= '0;
      tune_consec      <= '0;
      div_go           <= 1'b0;
    end else begin
      done        <= 1'b0;
      dll_ctrl_we <= 1'b0;
      div_go      <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          err_slow_clk     <= 1'b0;
          err_lock_timeout <= 1'b0;
          if (too_slow) begin
            err_slow_clk <= 1'b1;
            done         <= 1'b1;
          end else if (dll_ctrl_rd[EN_BIT]) begin
            div_go <= 1'b1;
            state  <= S_CALC;
          end else begin
            dll_ctrl_wr <= en_word;
            dll_ctrl_we <= 1'b1;
            state       <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (lock_sync[1]) begin
            div_go <= 1'b1;
            state  <= S_CALC;
          end else if (win_over) begin
            err_lock_timeout <= 1'b1;
            done             <= 1'b1;
            state            <= S_IDLE;
          end
        end
        S_CALC: if (div_fin) begin
          tune_step   <= (div_q > STEP_MAX) ? STEP_MAX[STEP_W-1:0] : div_q[STEP_W-1:0];
          tune_consec <= consec_cfg;
          done        <= 1'b1;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4
  we_shape_chk: assert property (@(posedge clk) disable iff (rst)
    dll_ctrl_we |-> (dll_ctrl_wr[EN_BIT] && dll_ctrl_wr[FLOCK_BIT] && !dll_ctrl_wr[BYP_BIT]));
  // R10
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    dll_ctrl_we |=> !dll_ctrl_we);
  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(err_slow_clk && err_lock_timeout));
  // R2
  slow_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err_slow_clk) |-> !dll_ctrl_we);
  // R6
  timeout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err_lock_timeout) |-> $stable(tune_step));
endmodule

// File: tb/dll_lock_supervisor_tb.sv
module dll_lock_supervisor_tb;
  localparam int LOCKN = 64;

  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [19:0] card_khz = 0;
  logic        new_variant = 0;
  logic [31:0] dll_ctrl_rd = 0;
  logic        dll_lock = 0;
  logic [9:0]  dll_delay = 0;
  logic [7:0]  step_div = 0;
  logic [3:0]  consec_cfg = 0;
  logic [31:0] dll_ctrl_wr;
  logic        dll_ctrl_we, done, err_slow_clk, err_lock_timeout;
  logic [5:0]  tune_step;
  logic [3:0]  tune_consec;

  always #4 clk = ~clk;

  dll_lock_supervisor #(.LOCK_CYCLES(LOCKN)) u_dut (
    .clk(clk), .rst(rst), .start(start), .card_khz(card_khz),
    .new_variant(new_variant), .dll_ctrl_rd(dll_ctrl_rd), .dll_lock(dll_lock),
    .dll_delay(dll_delay), .step_div(step_div), .consec_cfg(consec_cfg),
    .dll_ctrl_wr(dll_ctrl_wr), .dll_ctrl_we(dll_ctrl_we), .done(done),
    .err_slow_clk(err_slow_clk), .err_lock_timeout(err_lock_timeout),
    .tune_step(tune_step), .tune_consec(tune_consec));

  typedef struct {
    logic        e_slow;
    logic        e_to;
    int          writes;
    logic [31:0] word;
    logic [5:0]  step;
    logic [3:0]  cons;
  } exp_t;

  exp_t exq[$];
  int checks = 0;
  int fails = 0;
  int wcnt = 0;
  logic [31:0] wword = 0;
  logic [5:0]  last_step = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (dll_ctrl_we) begin
        wcnt++;
        wword = dll_ctrl_wr;
      end
      if (done && exq.size() > 0) begin
        exp_t e;
        e = exq.pop_front();
        chk(err_slow_clk == e.e_slow, "R2 slow flag", 32'(err_slow_clk), 32'(e.e_slow));
        chk(err_lock_timeout == e.e_to, "R6 timeout flag", 32'(err_lock_timeout), 32'(e.e_to));
        chk(wcnt == e.writes, "R3/R10 write count", 32'(wcnt), 32'(e.writes));
        if (e.writes == 1)
          chk(wword == e.word, "R4/R5 write word", wword, e.word);
        if (!e.e_slow && !e.e_to) begin
          chk(tune_step == e.step, "R7/R8 step", 32'(tune_step), 32'(e.step));
          chk(tune_consec == e.cons, "R9 consec", 32'(tune_consec), 32'(e.cons));
          last_step = e.step;
        end else if (e.e_to) begin
          chk(tune_step == last_step, "R6 step held", 32'(tune_step), 32'(last_step));
        end
        wcnt = 0;
      end
    end
  end

  function automatic logic [31:0] model_word(input logic [31:0] rd, input logic nv);
    logic [31:0] w;
    w = rd;
    w[31] = 1'b1; w[5] = 1'b1; w[0] = 1'b0;
    w[21:16] = 6'h1F; w[29:24] = 6'h1F;
    if (nv) begin w[23] = 1'b1; w[30] = 1'b0; end
    else w[30] = 1'b1;
    return w;
  endfunction

  task automatic run_req(input int khz, input logic [31:0] rd, input logic nv,
                         input int lock_dly, input int dly, input int dv, input int cons);
    exp_t e;
    int q;
    int dd;
    dd = (dv == 0) ? 1 : dv;
    q = dly / dd;
    e.e_slow = (khz <= 52000);
    e.e_to   = !e.e_slow && !rd[31] && (lock_dly < 0);
    e.writes = (!e.e_slow && !rd[31]) ? 1 : 0;
    e.word   = model_word(rd, nv);
    e.step   = (q > 63) ? 6'd63 : 6'(q);
    e.cons   = 4'(cons);
    exq.push_back(e);
    @(negedge clk);
    card_khz = 20'(khz); dll_ctrl_rd = rd; new_variant = nv;
    dll_delay = 10'(dly); step_div = 8'(dv); consec_cfg = 4'(cons);
    dll_lock = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    if (e.writes == 1 && lock_dly >= 0) begin
      repeat (lock_dly) @(negedge clk);
      dll_lock = 1;
    end
    while (!done) @(negedge clk);
    dll_lock = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!done && !dll_ctrl_we, "R1 strobes", {30'd0, done, dll_ctrl_we}, 32'd0);
    chk(!err_slow_clk && !err_lock_timeout, "R1 errors", {30'd0, err_slow_clk, err_lock_timeout}, 32'd0);
    chk(tune_step == 0 && tune_consec == 0, "R1 outputs", {22'd0, tune_step, tune_consec}, 32'd0);
    // R2 boundary: exactly threshold rejected
    run_req(52000, 32'h0000_0000, 1, 10, 100, 4, 3);
    run_req(25000, 32'h0000_0000, 0, 10, 100, 4, 3);
    // R4 R5 new variant, R7 plain division, R9 consec
    run_req(52001, 32'h4000_0001, 1, 10, 200, 8, 5);
    // R5 old variant, other bits preserved
    run_req(200000, 32'h0A5C_0E0F, 0, 20, 63, 1, 9);
    // R3 already enabled: no write, step still computed
    run_req(200000, 32'h8000_0000, 1, -1, 40, 0, 7);
    // R6 timeout: no lock at all
    run_req(150000, 32'h0000_0000, 1, -1, 100, 2, 1);
    // R6 late lock inside window
    run_req(150000, 32'h0000_0000, 0, 55, 7, 200, 2);
    // R8 saturation
    run_req(200000, 32'h0000_0000, 1, 3, 1000, 3, 15);
    run_req(200000, 32'h8000_0000, 0, -1, 64, 1, 0);
    // R7 divider zero treated as one
    run_req(200000, 32'h0000_0000, 1, 5, 33, 0, 4);
    summary();
  end
endmodule